// File: doc/BRIEF.md
# Two-Cycle Command Register for a Reprogrammable Byte Memory

This block is the device-side command interpreter of a byte-wide memory that can be erased and reprogrammed. It samples the active-low chip-enable, output-enable and write-enable strobes, a flag that reports whether the programming supply is present, the address bus and the data bus. A write cycle is the interval in which chip enable and write enable are both low. The address is taken when that interval opens and the data byte when it closes. Each completed write cycle is decoded as a command byte.

Some commands act at once. Erase needs the erase byte written twice, and program needs an address and data cycle after the set-up byte. The block reports its current mode and issues one-cycle start pulses for programming and bulk erase, together with the latched program address and data. It also steers an external array read port, so that verify reads return the array byte at the latched address, and it returns two fixed identifier bytes in identifier mode. The array itself, pulse timing and high-voltage generation are outside the block.

Strobes and the supply flag pass through a parameterised synchroniser. All outputs are therefore valid a fixed number of clock cycles after an input edge.

Top module: `mtp_cmd_decoder`

## Requirements
- R1: After reset `mode` is 0 (array read), `err_flag` is 0, `dout_oe` is 0, and neither `prog_pulse` nor `erase_pulse` has fired.
- R2: While `hv_ok` is low, `mode` is forced to 0, write cycles cause no mode change and no pulse, and they do not set `err_flag`.
- R3: A write cycle opens when `ce_n` and `we_n` are both low and closes when either returns high. The address is captured when the cycle opens, so a later change of `addr` inside the cycle has no effect on the latched address. The data byte is taken when the cycle closes.
- R4: Mode codes are 0 read, 1 erase set-up, 2 erasing, 3 erase verify, 4 program set-up, 5 programming, 6 program verify, 7 identifier. Writing 20H moves the block to mode 1. A second consecutive 20H moves it to mode 2 and emits a one-cycle `erase_pulse`. The next write ends the erase and is decoded as a normal command.
- R5: 40H moves the block to mode 4. The next write cycle, whatever its byte, moves the block to mode 5 and emits a one-cycle `prog_pulse`, with `op_addr` and `op_data` holding that cycle's address and data.
- R6: In mode 4, an FFH write is taken as program data of all ones (mode 5, pulse with `op_data` = FFH). A second FFH then returns the block to mode 0.
- R7: 90H selects mode 7. Reads then return C2H when `addr[0]` is 0 and CFH when `addr[0]` is 1.
- R8: `dout_oe` is high only while `ce_n` and `oe_n` are low and `we_n` is high. Otherwise `dout_oe` is 0 and `dout` is 0.
- R9: A byte other than 00H, 20H, A0H, 40H, C0H, FFH or 90H, written in any mode except 4, leaves `mode` unchanged and sets `err_flag`. The flag stays set until reset.
- R10: C0H selects mode 6, in which reads return the array byte at the last program address. A0H selects mode 3 and latches its own cycle address, and reads then return the array byte at that address. In both modes `arr_addr` shows the latched address, not the live bus.
- R11: 00H or FFH outside mode 4 selects mode 0, in which reads return the array byte at the live `addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| hv_ok | input | 1 | Programming supply present |
| addr | input | ADDR_W | Address bus |
| din | input | DATA_W | Data bus into the block |
| arr_data | input | DATA_W | Byte returned by the array read port |
| arr_addr | output | ADDR_W | Address presented to the array read port |
| dout | output | DATA_W | Read data, 0 when not driving |
| dout_oe | output | 1 | Read data drive enable |
| mode | output | 3 | Current mode code |
| err_flag | output | 1 | Sticky unrecognised-command flag |
| prog_pulse | output | 1 | One-cycle program start |
| erase_pulse | output | 1 | One-cycle bulk erase start |
| op_addr | output | ADDR_W | Latched program address |
| op_data | output | DATA_W | Latched program data |

## Verification
The bench builds the block with a 17-bit address, 8-bit data and a two-stage synchroniser. That depth makes the three-register delay from a strobe edge to a mode change observable, and it places the latching of the address at the opening of the write cycle before a deliberate mid-cycle address change. The full address width lets the array model return a byte that depends on the upper address bits. A verify read that used the live bus instead of the latched address would then return a visibly different byte.

// File: rtl/mtp_cmd_pkg.sv
package mtp_cmd_pkg;

   typedef enum logic [2:0] {
      M_READ    = 3'd0,
      M_ERS_SET = 3'd1,
      M_ERS     = 3'd2,
      M_ERS_VFY = 3'd3,
      M_PGM_SET = 3'd4,
      M_PGM     = 3'd5,
      M_PGM_VFY = 3'd6,
      M_IDENT   = 3'd7
   } mode_t;

   localparam logic [7:0] K_READ  = 8'h00;
   localparam logic [7:0] K_ERASE = 8'h20;
   localparam logic [7:0] K_EVFY  = 8'hA0;
   localparam logic [7:0] K_PGM   = 8'h40;
   localparam logic [7:0] K_PVFY  = 8'hC0;
   localparam logic [7:0] K_RST   = 8'hFF;
   localparam logic [7:0] K_IDENT = 8'h90;

endpackage

// File: rtl/mtp_strobe_sync.sv
module mtp_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   input  logic hv_ok,
   output logic ce_s,
   output logic oe_s,
   output logic we_s,
   output logic hv_s
);
   localparam logic [3:0] IDLE_VAL = 4'b1110;

   logic [3:0] raw;
   logic [3:0] synced;

   assign raw = {ce_n, oe_n, we_n, hv_ok};

   if (STAGES == 0) begin : g_direct
      assign synced = raw;
   end else begin : g_chain
      logic [3:0] pipe [STAGES];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= IDLE_VAL;
         end else begin
            pipe[0] <= raw;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
         end
      end
      assign synced = pipe[STAGES-1];
   end

   assign {ce_s, oe_s, we_s, hv_s} = synced;

endmodule

// File: rtl/mtp_cmd_fsm.sv
module mtp_cmd_fsm
   import mtp_cmd_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce_s,
   input  logic              we_s,
   input  logic              hv_s,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output mode_t             mode,
   output logic              err_flag,
   output logic              prog_pulse,
   output logic              erase_pulse,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic [ADDR_W-1:0] ver_addr
);
   logic              wr_now, wr_prev, wr_start, wr_end;
   logic [ADDR_W-1:0] addr_lat;
   mode_t             nxt_mode;
   logic              bad_cmd, go_pgm, go_ers, set_ver;

   assign wr_now   = ~ce_s & ~we_s;
   assign wr_start = wr_now & ~wr_prev;
   assign wr_end   = ~wr_now & wr_prev;

   always_comb begin
      nxt_mode = mode;
      bad_cmd  = 1'b0;
      go_pgm   = 1'b0;
      go_ers   = 1'b0;
      set_ver  = 1'b0;
      if (mode == M_PGM_SET) begin
         nxt_mode = M_PGM;
         go_pgm   = 1'b1;
      end else if (mode == M_ERS_SET && din == K_ERASE) begin
         nxt_mode = M_ERS;
         go_ers   = 1'b1;
      end else begin
         case (din)
            K_READ, K_RST: nxt_mode = M_READ;
            K_ERASE:       nxt_mode = M_ERS_SET;
            K_EVFY: begin
               nxt_mode = M_ERS_VFY;
               set_ver  = 1'b1;
            end
            K_PGM:         nxt_mode = M_PGM_SET;
            K_PVFY:        nxt_mode = M_PGM_VFY;
            K_IDENT:       nxt_mode = M_IDENT;
            default:       bad_cmd  = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_prev     <= 1'b0;
         addr_lat    <= '0;
         mode        <= M_READ;
         err_flag    <= 1'b0;
         prog_pulse  <= 1'b0;
         erase_pulse <= 1'b0;
         prog_addr   <= '0;
         prog_data   <= '0;
         ver_addr    <= '0;
      end else begin
         wr_prev     <= wr_now;
         prog_pulse  <= 1'b0;
         erase_pulse <= 1'b0;
         if (wr_start) addr_lat <= addr;
         if (!hv_s) begin
            mode <= M_READ;
         end else if (wr_end) begin
            mode <= nxt_mode;
            if (bad_cmd) err_flag <= 1'b1;
            if (go_pgm) begin
               prog_pulse <= 1'b1;
               prog_addr  <= addr_lat;
               prog_data  <= din;
            end
            if (go_ers) erase_pulse <= 1'b1;
            if (set_ver) ver_addr <= addr_lat;
         end
      end
   end

   // R2: without the supply flag the block falls back to read and starts nothing
   p_hv_forces_read_r2: assert property (@(posedge clk) disable iff (rst)
      !hv_s |=> (mode == M_READ && !prog_pulse && !erase_pulse));

   // R5: the program start lasts a single cycle and follows program set-up
   p_prog_single_r5: assert property (@(posedge clk) disable iff (rst)
      prog_pulse |=> !prog_pulse);
   p_prog_from_setup_r5: assert property (@(posedge clk) disable iff (rst)
      prog_pulse |-> $past(mode) == M_PGM_SET);

   // R4: a bulk erase only starts from erase set-up
   p_erase_from_setup_r4: assert property (@(posedge clk) disable iff (rst)
      erase_pulse |-> $past(mode) == M_ERS_SET);

   // R9: the error flag never clears on its own
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      err_flag |=> err_flag);

endmodule

// File: rtl/mtp_read_path.sv
module mtp_read_path
   import mtp_cmd_pkg::*;
#(
   parameter int          ADDR_W   = 17,
   parameter int          DATA_W   = 8,
   parameter logic [7:0]  MFR_CODE = 8'hC2,
   parameter logic [7:0]  DEV_CODE = 8'hCF
) (
   input  mode_t             mode,
   input  logic              ce_s,
   input  logic              oe_s,
   input  logic              we_s,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] prog_addr,
   input  logic [ADDR_W-1:0] ver_addr,
   input  logic [DATA_W-1:0] arr_data,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe
);
   logic [DATA_W-1:0] sel_data;

   always_comb begin
      case (mode)
         M_PGM_VFY: arr_addr = prog_addr;
         M_ERS_VFY: arr_addr = ver_addr;
         default:   arr_addr = addr;
      endcase
   end

   always_comb begin
      if (mode == M_IDENT) sel_data = addr[0] ? DEV_CODE : MFR_CODE;
      else                 sel_data = arr_data;
   end

   assign dout_oe = ~ce_s & ~oe_s & we_s;
   assign dout    = dout_oe ? sel_data : '0;

endmodule

// File: rtl/mtp_cmd_decoder.sv
module mtp_cmd_decoder
   import mtp_cmd_pkg::*;
#(
   parameter int         ADDR_W      = 17,
   parameter int         DATA_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] MFR_CODE    = 8'hC2,
   parameter logic [7:0] DEV_CODE    = 8'hCF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              hv_ok,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] arr_data,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe,
   output logic [2:0]        mode,
   output logic              err_flag,
   output logic              prog_pulse,
   output logic              erase_pulse,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data
);
   if (DATA_W != 8) begin : g_bad_data_w
      $error("mtp_cmd_decoder: command bytes need DATA_W of 8");
   end
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("mtp_cmd_decoder: ADDR_W must be at least 2");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("mtp_cmd_decoder: SYNC_STAGES must lie in 0..4");
   end

   logic              ce_s, oe_s, we_s, hv_s;
   mode_t             mode_q;
   logic [ADDR_W-1:0] ver_addr;

   mtp_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst),
      .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .hv_ok(hv_ok),
      .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s), .hv_s(hv_s)
   );

   mtp_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk(clk), .rst(rst),
      .ce_s(ce_s), .we_s(we_s), .hv_s(hv_s),
      .addr(addr), .din(din),
      .mode(mode_q), .err_flag(err_flag),
      .prog_pulse(prog_pulse), .erase_pulse(erase_pulse),
      .prog_addr(op_addr), .prog_data(op_data), .ver_addr(ver_addr)
   );

   mtp_read_path #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
   ) u_rd (
      .mode(mode_q), .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s),
      .addr(addr), .prog_addr(op_addr), .ver_addr(ver_addr),
      .arr_data(arr_data), .arr_addr(arr_addr),
      .dout(dout), .dout_oe(dout_oe)
   );

   assign mode = mode_q;

   // R8: read data is never driven while a write strobe is low
   p_no_drive_in_write_r8: assert property (@(posedge clk) disable iff (rst)
      !we_s |-> !dout_oe);

endmodule

// File: tb/tb_mtp_cmd_decoder.sv
`timescale 1ns/1ps
module tb_mtp_cmd_decoder;
   localparam int AW = 17;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst;
   logic          ce_n, oe_n, we_n, hv_ok;
   logic [AW-1:0] addr;
   logic [DW-1:0] din;
   logic [DW-1:0] arr_data;
   logic [AW-1:0] arr_addr;
   logic [DW-1:0] dout;
   logic          dout_oe;
   logic [2:0]    mode;
   logic          err_flag, prog_pulse, erase_pulse;
   logic [AW-1:0] op_addr;
   logic [DW-1:0] op_data;

   int checks = 0;
   int fails  = 0;
   int n_pg = 0, n_er = 0;
   logic [AW-1:0] cap_pa;
   logic [DW-1:0] cap_pd;

   // bench-side model state
   logic [2:0]    em;
   logic          eerr;
   int            e_pg, e_er;
   logic [AW-1:0] epa, eva;
   logic [DW-1:0] epd;

   always #4 clk = ~clk;

   function automatic logic [DW-1:0] arr_fn(input logic [AW-1:0] a);
      return a[7:0] ^ a[15:8] ^ {7'h0, a[16]} ^ 8'h3C;
   endfunction

   assign arr_data = arr_fn(arr_addr);

   mtp_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .hv_ok(hv_ok), .addr(addr), .din(din), .arr_data(arr_data),
      .arr_addr(arr_addr), .dout(dout), .dout_oe(dout_oe), .mode(mode),
      .err_flag(err_flag), .prog_pulse(prog_pulse),
      .erase_pulse(erase_pulse), .op_addr(op_addr), .op_data(op_data)
   );

   always @(negedge clk) begin
      if (prog_pulse) begin
         n_pg++;
         cap_pa = op_addr;
         cap_pd = op_data;
      end
      if (erase_pulse) n_er++;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_raw(input logic [AW-1:0] a0, input logic [AW-1:0] a1, input logic [DW-1:0] d);
      addr = a0;
      din  = d;
      @(negedge clk);
      ce_n = 1'b0;
      we_n = 1'b0;
      repeat (6) @(negedge clk);
      addr = a1;
      repeat (2) @(negedge clk);
      we_n = 1'b1;
      repeat (6) @(negedge clk);
      ce_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] q, output logic oe);
      addr = a;
      @(negedge clk);
      ce_n = 1'b0;
      oe_n = 1'b0;
      repeat (6) @(negedge clk);
      q  = dout;
      oe = dout_oe;
      oe_n = 1'b1;
      ce_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   // expected next state, written from the requirement list
   task automatic model(input logic [AW-1:0] a, input logic [DW-1:0] d);
      if (em == 3'd4) begin
         em = 3'd5; e_pg++; epa = a; epd = d;
      end else if (em == 3'd1 && d == 8'h20) begin
         em = 3'd2; e_er++;
      end else begin
         case (d)
            8'h00, 8'hFF: em = 3'd0;
            8'h20:        em = 3'd1;
            8'hA0: begin  em = 3'd3; eva = a; end
            8'h40:        em = 3'd4;
            8'hC0:        em = 3'd6;
            8'h90:        em = 3'd7;
            default:      eerr = 1'b1;
         endcase
      end
   endtask

   task automatic chk_state(input string req);
      chk({req, " mode"}, mode, em);
      chk({req, " err_flag"}, err_flag, eerr);
      chk({req, " prog pulses"}, n_pg, e_pg);
      chk({req, " erase pulses"}, n_er, e_er);
      if (e_pg > 0) begin
         chk({req, " op_addr"}, cap_pa, epa);
         chk({req, " op_data"}, cap_pd, epd);
      end
   endtask

   task automatic cmd(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr_raw(a, a, d);
      model(a, d);
      chk_state(req);
   endtask

   task automatic read_expect(input string req, input logic [AW-1:0] a);
      logic [DW-1:0] q, exp;
      logic          oe;
      do_read(a, q, oe);
      case (em)
         3'd3:    exp = arr_fn(eva);
         3'd6:    exp = arr_fn(epa);
         3'd7:    exp = a[0] ? 8'hCF : 8'hC2;
         default: exp = arr_fn(a);
      endcase
      chk({req, " read oe"}, oe, 1'b1);
      chk({req, " read data"}, q, exp);
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [DW-1:0] q;
      logic          oe;
      void'($urandom(32'h5EED_1234));
      rst = 1'b1; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; hv_ok = 1'b1;
      addr = '0; din = '0;
      em = 3'd0; eerr = 1'b0; e_pg = 0; e_er = 0; epa = '0; epd = '0; eva = '0;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      repeat (5) @(negedge clk);

      // R1 reset state
      chk("R1 mode", mode, 3'd0);
      chk("R1 err_flag", err_flag, 1'b0);
      chk("R1 dout_oe", dout_oe, 1'b0);
      chk("R1 pulses", n_pg + n_er, 0);

      // R11 array read at live address
      read_expect("R11", 17'h1A55A);

      // R8 one enable missing -> no drive, zero data
      addr = 17'h00123; ce_n = 1'b0; oe_n = 1'b1;
      repeat (6) @(negedge clk);
      chk("R8 oe high dout_oe", dout_oe, 1'b0);
      chk("R8 oe high dout", dout, 8'h00);
      ce_n = 1'b1; oe_n = 1'b0;
      repeat (6) @(negedge clk);
      chk("R8 ce high dout_oe", dout_oe, 1'b0);
      chk("R8 ce high dout", dout, 8'h00);
      oe_n = 1'b1;
      repeat (3) @(negedge clk);

      // R4 erase needs two 20H writes, next write ends it
      cmd("R4 first 20H", 17'h0, 8'h20);
      cmd("R4 second 20H", 17'h0, 8'h20);
      cmd("R4 verify ends erase", 17'h0ABCD, 8'hA0);
      read_expect("R10 erase verify", 17'h10001);

      // R5 and R3: address taken when the cycle opens
      cmd("R5 set-up", 17'h0, 8'h40);
      wr_raw(17'h13579, 17'h02468, 8'h5A);
      model(17'h13579, 8'h5A);
      chk_state("R3 R5 program");
      cmd("R10 program verify cmd", 17'h0, 8'hC0);
      read_expect("R10 program verify", 17'h00F0F);

      // R6 two FFH writes out of program set-up
      cmd("R6 set-up", 17'h0, 8'h40);
      cmd("R6 first FFH", 17'h1FFFF, 8'hFF);
      chk("R6 null data", cap_pd, 8'hFF);
      cmd("R6 second FFH", 17'h0, 8'hFF);

      // R7 identifier bytes
      cmd("R7 ident cmd", 17'h0, 8'h90);
      read_expect("R7 manufacturer", 17'h0);
      read_expect("R7 device", 17'h1);

      // R9 unknown byte keeps mode, flag sticks
      cmd("R9 unknown in ident", 17'h0, 8'h13);
      cmd("R9 back to read", 17'h0, 8'h00);
      chk("R9 sticky", err_flag, 1'b1);

      // R2 supply low: fall back to read, writes ignored
      cmd("R2 ident before", 17'h0, 8'h90);
      hv_ok = 1'b0;
      repeat (5) @(negedge clk);
      em = 3'd0;
      chk("R2 forced read", mode, 3'd0);
      wr_raw(17'h0, 17'h0, 8'h40);
      wr_raw(17'h0, 17'h0, 8'h77);
      chk_state("R2 writes ignored");
      hv_ok = 1'b1;
      repeat (5) @(negedge clk);

      // random command streams
      for (int it = 0; it < 300; it++) begin
         logic [AW-1:0] a;
         logic [DW-1:0] d;
         int            pick;
         a    = AW'($urandom());
         pick = int'($urandom_range(0, 8));
         case (pick)
            0: d = 8'h00;
            1: d = 8'h20;
            2: d = 8'hA0;
            3: d = 8'h40;
            4: d = 8'hC0;
            5: d = 8'hFF;
            6: d = 8'h90;
            7: d = 8'h20;
            default: d = 8'($urandom());
         endcase
         if ($urandom_range(0, 19) == 0) begin
            hv_ok = 1'b0;
            repeat (4) @(negedge clk);
            wr_raw(a, a, d);
            em = 3'd0;
            chk_state("R2 random");
            hv_ok = 1'b1;
            repeat (4) @(negedge clk);
         end else begin
            cmd("R4 R5 R9 random", a, d);
            if (em == 3'd0 || em == 3'd3 || em == 3'd6 || em == 3'd7)
               read_expect("R7 R10 R11 random", AW'($urandom()));
         end
      end

      do_read(17'h00042, q, oe);
      chk("R8 final read enable", oe, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule